// File: doc/BRIEF.md
# Indirect PLL Reconfiguration Register Bridge

This block is a memory-mapped slave. Through it a host reaches a small bank of PLL control sub-registers, one bank for each channel, without mapping those sub-registers directly. The host loads a logical channel number, a 4-bit sub-register offset and a data word into three host registers. It then writes a command bit into a control/status register. The bridge translates the logical channel to a physical channel through an internal table, which reset loads as an identity mapping. It then runs the access as a fixed multi-cycle internal transfer. While the transfer runs it reports busy. It rejects illegal requests and flags them with an error bit.

Two sub-registers do more than hold data. A committed write to one of them switches the channel's reference-clock selection, and a committed write to the other switches its PLL selection. Each selection is a registered output, and the switch is marked by a one-cycle strobe for that channel. Two further sub-registers are read-only mapping words that describe the current channel.

Top module: `pllrc_bridge`

## Requirements
- R1: Host register 0x40 holds a 10-bit channel number and 0x43 a 4-bit offset. Register 0x44 holds the data word: a host write stores wdata[15:0] and clears bits [24:16], and reads return the stored 25-bit value. A read returns the addressed register in host_rdata on the cycle after host_rd is sampled, with unused bits 0. Unmapped addresses read as 0.
- R2: Control/status register 0x42 decodes bit0 = start write and bit1 = start read on a host write. These bits read back as 0. Reads return busy in bit 8 and error in bit 9.
- R3: An accepted command raises busy in the cycle after the control write. Busy stays high for exactly 4 cycles and falls in the cycle in which the access takes effect.
- R4: An accepted indirect read loads the addressed sub-register word into data register 0x44 when busy falls.
- R5: Offset 0 selects the reference clock. An accepted write with data[2:0] below 5 sets the channel's 3-bit field of refclk_sel_o (bits 3p+2:3p for physical channel p) to data[2:0], and pulses refclk_switch_o[p] for one cycle as busy falls.
- R6: Offset 1 selects the PLL. An accepted write with data[2:0] below 4 sets the channel's field of pll_sel_o and pulses pll_switch_o[p] for one cycle as busy falls.
- R7: Indirect reads return these words. Offset 0 returns the reference-clock selection and offset 1 the PLL selection, both zero-extended. Offset 2 returns the reference-clock selection in bits [24:22] and the physical channel in bits [9:0]. Offset 3 returns the PLL selection in bits [14:12] and the physical channel in bits [9:0]. Offsets 4 to 15 return 0. All other bits are 0.
- R8: A command is rejected if the channel is 8 or more, both command bits are set, the write targets offset 2 or above, or the write index is out of range for its offset. A rejected command sets error, does not raise busy and changes no selection.
- R9: A command written while busy is high is rejected and sets error. The running access still completes unchanged.
- R10: An accepted command clears error. A control write with neither command bit set leaves busy and error unchanged.
- R11: After reset all selections are 0, busy and error are 0, and the host registers read 0. The channel table is the identity, so the physical channel equals the logical channel.
- R12: A committed access changes only the selection of its own physical channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 7 | Host word address |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| busy_o | output | 1 | Indirect access in progress |
| refclk_sel_o | output | 24 | Reference-clock selection, 3 bits per physical channel |
| pll_sel_o | output | 24 | PLL selection, 3 bits per physical channel |
| refclk_switch_o | output | 8 | One-cycle reference-clock switch strobe per channel |
| pll_switch_o | output | 8 | One-cycle PLL switch strobe per channel |

## Verification
Host register reads appear in host_rdata one cycle after the read is sampled, so the bench drives on falling edges and reads the result at the next falling edge. After an accepted control write, busy is checked high at the falling edge right after the write and at each of the next three. It is then checked low at the fourth, together with the switch strobes and the new selections, which change in that same cycle. A rejected command is checked to leave busy low at the first falling edge. The error bit and the loaded data word are then read back through the host registers.

// File: rtl/pllrc_pkg.sv
package pllrc_pkg;
  localparam int unsigned HADDR_W  = 7;
  localparam int unsigned HDATA_W  = 32;
  localparam int unsigned CHAN_W   = 10;
  localparam int unsigned OFS_W    = 4;
  localparam int unsigned DWORD_W  = 16;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned MAPW     = 25;
  localparam int unsigned PLLMAP_W = 15;

  localparam logic [HADDR_W-1:0] A_CHAN = 7'h40;
  localparam logic [HADDR_W-1:0] A_CTRL = 7'h42;
  localparam logic [HADDR_W-1:0] A_OFS  = 7'h43;
  localparam logic [HADDR_W-1:0] A_DATA = 7'h44;

  localparam int unsigned CB_WR   = 0;
  localparam int unsigned CB_RD   = 1;
  localparam int unsigned SB_BUSY = 8;
  localparam int unsigned SB_ERR  = 9;

  localparam logic [OFS_W-1:0] SUB_REFSEL = 4'd0;
  localparam logic [OFS_W-1:0] SUB_PLLSEL = 4'd1;
  localparam logic [OFS_W-1:0] SUB_REFMAP = 4'd2;
  localparam logic [OFS_W-1:0] SUB_PLLMAP = 4'd3;

  typedef struct packed {
    logic              is_wr;
    logic [CHAN_W-1:0] phys;
    logic [OFS_W-1:0]  ofs;
    logic [SEL_W-1:0]  idx;
  } pllrc_req_t;
endpackage

// File: rtl/pllrc_chanmap.sv
module pllrc_chanmap import pllrc_pkg::*; #(
  parameter int unsigned NUM_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [CHAN_W-1:0] logical_i,
  output logic [CHAN_W-1:0] phys_o,
  output logic              hit_o
);
  localparam int unsigned IDX_W = (NUM_LOG > 1) ? $clog2(NUM_LOG) : 1;
  localparam logic [CHAN_W-1:0] NLOG_C = CHAN_W'(NUM_LOG);

  logic [CHAN_W-1:0] tbl_q [NUM_LOG];
  logic [CHAN_W-1:0] tbl_d [NUM_LOG];

  always_comb begin
    for (int i = 0; i < int'(NUM_LOG); i++) tbl_d[i] = tbl_q[i];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_LOG); i++) tbl_q[i] <= CHAN_W'(i);
    end else begin
      for (int i = 0; i < int'(NUM_LOG); i++) tbl_q[i] <= tbl_d[i];
    end
  end

  always_comb begin
    hit_o  = (logical_i < NLOG_C);
    phys_o = '0;
    if (hit_o) phys_o = tbl_q[logical_i[IDX_W-1:0]];
  end

  // R11: a translated channel always lands inside the physical range
  a_r11_map_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
    hit_o |-> (phys_o < NLOG_C));
endmodule

// File: rtl/pllrc_hostregs.sv
module pllrc_hostregs import pllrc_pkg::*; (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [HADDR_W-1:0] addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [HDATA_W-1:0] wdata_i,
  output logic [HDATA_W-1:0] rdata_o,
  output logic [CHAN_W-1:0]  chan_o,
  output logic [OFS_W-1:0]   ofs_o,
  output logic [SEL_W-1:0]   idx_o,
  output logic               cmd_en_o,
  output logic [1:0]         cmd_bits_o,
  input  logic               busy_i,
  input  logic               err_i,
  input  logic               ld_en_i,
  input  logic [MAPW-1:0]    ld_data_i
);
  logic [CHAN_W-1:0]  chan_q, chan_d;
  logic [OFS_W-1:0]   ofs_q, ofs_d;
  logic [MAPW-1:0]    data_q, data_d;
  logic [HDATA_W-1:0] rdata_q, rdata_d, rd_word, stat_word;
  logic               wr_chan, wr_ofs, wr_data;
  logic [HDATA_W-DWORD_W-1:0] unused_wdata_hi;

  assign unused_wdata_hi = wdata_i[HDATA_W-1:DWORD_W];

  always_comb begin
    wr_chan = wr_i && (addr_i == A_CHAN);
    wr_ofs  = wr_i && (addr_i == A_OFS);
    wr_data = wr_i && (addr_i == A_DATA);

    chan_d = wr_chan ? wdata_i[CHAN_W-1:0] : chan_q;
    ofs_d  = wr_ofs  ? wdata_i[OFS_W-1:0]  : ofs_q;
    // engine load takes priority over a host write in the same cycle
    if (ld_en_i)      data_d = ld_data_i;
    else if (wr_data) data_d = MAPW'(wdata_i[DWORD_W-1:0]);
    else              data_d = data_q;

    stat_word          = '0;
    stat_word[SB_BUSY] = busy_i;
    stat_word[SB_ERR]  = err_i;

    case (addr_i)
      A_CHAN:  rd_word = HDATA_W'(chan_q);
      A_CTRL:  rd_word = stat_word;
      A_OFS:   rd_word = HDATA_W'(ofs_q);
      A_DATA:  rd_word = HDATA_W'(data_q);
      default: rd_word = '0;
    endcase
    rdata_d = rd_i ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q  <= '0;
      ofs_q   <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      chan_q  <= chan_d;
      ofs_q   <= ofs_d;
      data_q  <= data_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o    = rdata_q;
  assign chan_o     = chan_q;
  assign ofs_o      = ofs_q;
  assign idx_o      = data_q[SEL_W-1:0];
  assign cmd_en_o   = wr_i && (addr_i == A_CTRL);
  assign cmd_bits_o = {wdata_i[CB_RD], wdata_i[CB_WR]};

  // R1: read data only moves when a read is sampled
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  // R1: channel register changes only through a write to its address
  a_r1_chan_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_i && (addr_i == A_CHAN)) |=> $stable(chan_o));
endmodule

// File: rtl/pllrc_engine.sv
module pllrc_engine import pllrc_pkg::*; #(
  parameter int unsigned NUM_LOG    = 8,
  parameter int unsigned NUM_REFCLK = 5,
  parameter int unsigned NUM_PLL    = 4,
  parameter int unsigned HS_CYC     = 4
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic                      cmd_en_i,
  input  logic [1:0]                cmd_bits_i,
  input  logic                      chan_hit_i,
  input  logic [CHAN_W-1:0]         phys_i,
  input  logic [OFS_W-1:0]          ofs_i,
  input  logic [SEL_W-1:0]          idx_i,
  output logic                      busy_o,
  output logic                      err_o,
  output logic                      ld_en_o,
  output logic [MAPW-1:0]           ld_data_o,
  output logic [NUM_LOG*SEL_W-1:0]  refclk_sel_o,
  output logic [NUM_LOG*SEL_W-1:0]  pll_sel_o,
  output logic [NUM_LOG-1:0]        refclk_sw_o,
  output logic [NUM_LOG-1:0]        pll_sw_o
);
  localparam int unsigned CNT_W = (HS_CYC > 1) ? $clog2(HS_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HS_CYC - 1);
  localparam logic [SEL_W:0] NREF_C = (SEL_W+1)'(NUM_REFCLK);
  localparam logic [SEL_W:0] NPLL_C = (SEL_W+1)'(NUM_PLL);

  logic             busy_q, busy_d, err_q, err_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  pllrc_req_t       req_q, req_d;
  logic wr_req, rd_req, any_cmd, bad_ofs, bad_idx, illegal, accept, reject, commit;
  logic [SEL_W-1:0] cur_ref, cur_pll;
  logic [MAPW-1:0]  rd_word;

  // request legality, decided on the cycle the control register is written
  always_comb begin
    wr_req  = cmd_bits_i[0];
    rd_req  = cmd_bits_i[1];
    any_cmd = cmd_en_i && (wr_req || rd_req);
    bad_ofs = wr_req && (ofs_i != SUB_REFSEL) && (ofs_i != SUB_PLLSEL);
    bad_idx = wr_req && (((ofs_i == SUB_REFSEL) && ({1'b0, idx_i} >= NREF_C)) ||
                         ((ofs_i == SUB_PLLSEL) && ({1'b0, idx_i} >= NPLL_C)));
    illegal = (wr_req && rd_req) || !chan_hit_i || bad_ofs || bad_idx;
    accept  = any_cmd && !busy_q && !illegal;
    reject  = any_cmd && (busy_q || illegal);
  end

  // sequencer next state
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    err_d  = err_q;
    req_d  = req_q;
    commit = busy_q && (cnt_q == LAST);
    if (busy_q) begin
      if (commit) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (accept) begin
      busy_d      = 1'b1;
      cnt_d       = '0;
      err_d       = 1'b0;
      req_d.is_wr = wr_req;
      req_d.phys  = phys_i;
      req_d.ofs   = ofs_i;
      req_d.idx   = idx_i;
    end
    if (reject) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      req_q  <= '0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      cnt_q  <= cnt_d;
      if (accept) req_q <= req_d;
    end
  end

  // per-physical-channel selection bank
  for (genvar g = 0; g < int'(NUM_LOG); g++) begin : g_chan
    logic             hit_g, ref_we, pll_we, ref_sw_q, pll_sw_q;
    logic [SEL_W-1:0] ref_q, pll_q;

    assign hit_g  = commit && req_q.is_wr && (req_q.phys == CHAN_W'(g));
    assign ref_we = hit_g && (req_q.ofs == SUB_REFSEL);
    assign pll_we = hit_g && (req_q.ofs == SUB_PLLSEL);

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_q    <= '0;
        pll_q    <= '0;
        ref_sw_q <= 1'b0;
        pll_sw_q <= 1'b0;
      end else begin
        ref_sw_q <= ref_we;
        pll_sw_q <= pll_we;
        if (ref_we) ref_q <= req_q.idx;
        if (pll_we) pll_q <= req_q.idx;
      end
    end

    assign refclk_sel_o[g*SEL_W +: SEL_W] = ref_q;
    assign pll_sel_o[g*SEL_W +: SEL_W]    = pll_q;
    assign refclk_sw_o[g]                 = ref_sw_q;
    assign pll_sw_o[g]                    = pll_sw_q;

    // R5, R6: stored selections stay within their allowed counts
    a_r5_ref_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
      ({1'b0, ref_q} < NREF_C));
    a_r6_pll_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
      ({1'b0, pll_q} < NPLL_C));
  end

  // read path: sub-register word for the latched request
  always_comb begin
    cur_ref = '0;
    cur_pll = '0;
    for (int i = 0; i < int'(NUM_LOG); i++) begin
      if (req_q.phys == CHAN_W'(i)) begin
        cur_ref = refclk_sel_o[i*SEL_W +: SEL_W];
        cur_pll = pll_sel_o[i*SEL_W +: SEL_W];
      end
    end
    rd_word = '0;
    case (req_q.ofs)
      SUB_REFSEL: rd_word = MAPW'(cur_ref);
      SUB_PLLSEL: rd_word = MAPW'(cur_pll);
      SUB_REFMAP: begin
        rd_word[MAPW-1 -: SEL_W] = cur_ref;
        rd_word[CHAN_W-1:0]      = req_q.phys;
      end
      SUB_PLLMAP: begin
        rd_word[PLLMAP_W-1 -: SEL_W] = cur_pll;
        rd_word[CHAN_W-1:0]          = req_q.phys;
      end
      default: rd_word = '0;
    endcase
  end

  assign ld_en_o   = commit && !req_q.is_wr;
  assign ld_data_o = rd_word;
  assign busy_o    = busy_q;
  assign err_o     = err_q;

  // R3: busy only rises after a control-register command
  a_r3_busy_from_cmd: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(cmd_en_i));
  // R3: the final handshake cycle always ends the access
  a_r3_busy_ends: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && (cnt_q == LAST)) |=> !busy_q);
  // R9: a command arriving during an access flags an error
  a_r9_busy_reject: assert property (@(posedge clk) disable iff (!rst_ni)
    (any_cmd && busy_q) |=> err_q);
  // R8: an illegal idle-time command leaves selections and busy untouched
  a_r8_no_side_effect: assert property (@(posedge clk) disable iff (!rst_ni)
    (any_cmd && !busy_q && illegal) |=>
      (!busy_q && err_q && $stable(refclk_sel_o) && $stable(pll_sel_o)));
  // R12: at most one channel switches at a time
  a_r12_one_ref_switch: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(refclk_sw_o));
  a_r12_one_pll_switch: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(pll_sw_o));
endmodule

// File: rtl/pllrc_bridge.sv
module pllrc_bridge import pllrc_pkg::*; #(
  parameter int unsigned NUM_LOG    = 8,
  parameter int unsigned NUM_REFCLK = 5,
  parameter int unsigned NUM_PLL    = 4,
  parameter int unsigned HS_CYC     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [HADDR_W-1:0]       host_addr,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [HDATA_W-1:0]       host_wdata,
  output logic [HDATA_W-1:0]       host_rdata,
  output logic                     busy_o,
  output logic [NUM_LOG*SEL_W-1:0] refclk_sel_o,
  output logic [NUM_LOG*SEL_W-1:0] pll_sel_o,
  output logic [NUM_LOG-1:0]       refclk_switch_o,
  output logic [NUM_LOG-1:0]       pll_switch_o
);
  logic [1:0]        rs_q;
  logic              rst_ni;
  logic [CHAN_W-1:0] chan, phys;
  logic [OFS_W-1:0]  ofs;
  logic [SEL_W-1:0]  idx;
  logic              cmd_en, chan_hit, busy, err, ld_en;
  logic [1:0]        cmd_bits;
  logic [MAPW-1:0]   ld_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  pllrc_hostregs u_regs (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .addr_i     (host_addr),
    .wr_i       (host_wr),
    .rd_i       (host_rd),
    .wdata_i    (host_wdata),
    .rdata_o    (host_rdata),
    .chan_o     (chan),
    .ofs_o      (ofs),
    .idx_o      (idx),
    .cmd_en_o   (cmd_en),
    .cmd_bits_o (cmd_bits),
    .busy_i     (busy),
    .err_i      (err),
    .ld_en_i    (ld_en),
    .ld_data_i  (ld_data)
  );

  pllrc_chanmap #(.NUM_LOG(NUM_LOG)) u_map (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .logical_i (chan),
    .phys_o    (phys),
    .hit_o     (chan_hit)
  );

  pllrc_engine #(
    .NUM_LOG    (NUM_LOG),
    .NUM_REFCLK (NUM_REFCLK),
    .NUM_PLL    (NUM_PLL),
    .HS_CYC     (HS_CYC)
  ) u_eng (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .cmd_en_i     (cmd_en),
    .cmd_bits_i   (cmd_bits),
    .chan_hit_i   (chan_hit),
    .phys_i       (phys),
    .ofs_i        (ofs),
    .idx_i        (idx),
    .busy_o       (busy),
    .err_o        (err),
    .ld_en_o      (ld_en),
    .ld_data_o    (ld_data),
    .refclk_sel_o (refclk_sel_o),
    .pll_sel_o    (pll_sel_o),
    .refclk_sw_o  (refclk_switch_o),
    .pll_sw_o     (pll_switch_o)
  );

  assign busy_o = busy;
endmodule

// File: tb/sim_pllrc_bridge.sv
module sim_pllrc_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk, rst_n, host_wr, host_rd, busy_o;
  logic [6:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic [23:0] refclk_sel_o, pll_sel_o;
  logic [7:0]  refclk_switch_o, pll_switch_o;

  int total, bad;
  int m_ref [NCH];
  int m_pll [NCH];
  int m_err;
  logic [31:0] m_data;

  pllrc_bridge u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy_o(busy_o), .refclk_sel_o(refclk_sel_o), .pll_sel_o(pll_sel_o),
    .refclk_switch_o(refclk_switch_o), .pll_switch_o(pll_switch_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic host_write(input logic [6:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [6:0] a, output logic [31:0] d);
    host_addr = a; host_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  function automatic logic [23:0] f_vec(input bit pll);
    logic [23:0] v = '0;
    for (int i = 0; i < NCH; i++) v[i*3 +: 3] = 3'(pll ? m_pll[i] : m_ref[i]);
    return v;
  endfunction

  function automatic bit f_illegal(input int ch, input int ofs, input int dat, input int bits);
    bit wr = bits[0];
    bit rd = bits[1];
    if (wr && rd) return 1;
    if (ch >= NCH) return 1;
    if (wr) begin
      if (ofs > 1) return 1;
      if (ofs == 0 && (dat & 7) >= 5) return 1;
      if (ofs == 1 && (dat & 7) >= 4) return 1;
    end
    return 0;
  endfunction

  function automatic logic [31:0] f_word(input int ch, input int ofs);
    case (ofs)
      0: return 32'(m_ref[ch]);
      1: return 32'(m_pll[ch]);
      2: return (32'(m_ref[ch]) << 22) | 32'(ch);
      3: return (32'(m_pll[ch]) << 12) | 32'(ch);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_state(input string req);
    logic [31:0] r;
    host_read(7'h42, r);
    chk(r == (32'(m_err) << 9), {req, " status"}, r, 32'(m_err) << 9);
    host_read(7'h44, r);
    chk(r == m_data, {req, " data"}, r, m_data);
    chk(refclk_sel_o == f_vec(0), {req, " R12 refsel"}, 32'(refclk_sel_o), 32'(f_vec(0)));
    chk(pll_sel_o == f_vec(1), {req, " R12 pllsel"}, 32'(pll_sel_o), 32'(f_vec(1)));
  endtask

  task automatic run_op(input int ch, input int ofs, input int dat, input int bits, input string req);
    bit ill;
    logic [7:0] exp_rs, exp_ps;
    host_write(7'h40, 32'(ch));
    host_write(7'h43, 32'(ofs));
    host_write(7'h44, 32'(dat));
    m_data = 32'(dat & 32'hFFFF);
    ill = f_illegal(ch, ofs, dat, bits);
    host_write(7'h42, 32'(bits));
    if (bits == 0) begin
      chk(busy_o == 1'b0, {req, " R10 no-cmd busy"}, 32'(busy_o), 0);
    end else if (ill) begin
      chk(busy_o == 1'b0, {req, " R8 reject busy"}, 32'(busy_o), 0);
      m_err = 1;
    end else begin
      chk(busy_o == 1'b1, {req, " R3 busy rise"}, 32'(busy_o), 1);
      repeat (3) begin
        @(negedge clk);
        chk(busy_o == 1'b1, {req, " R3 busy hold"}, 32'(busy_o), 1);
      end
      @(negedge clk);
      chk(busy_o == 1'b0, {req, " R3 busy fall"}, 32'(busy_o), 0);
      exp_rs = '0; exp_ps = '0;
      if (bits == 1 && ofs == 0) begin m_ref[ch] = dat & 7; exp_rs[ch] = 1'b1; end
      if (bits == 1 && ofs == 1) begin m_pll[ch] = dat & 7; exp_ps[ch] = 1'b1; end
      chk(refclk_switch_o == exp_rs, {req, " R5 ref strobe"}, 32'(refclk_switch_o), 32'(exp_rs));
      chk(pll_switch_o == exp_ps, {req, " R6 pll strobe"}, 32'(pll_switch_o), 32'(exp_ps));
      if (bits == 2) m_data = f_word(ch, ofs);
      m_err = 0;
    end
    check_state(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    total = 0; bad = 0; m_err = 0; m_data = '0;
    for (int i = 0; i < NCH; i++) begin m_ref[i] = 0; m_pll[i] = 0; end
    host_addr = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    chk(busy_o == 1'b0, "R11 busy", 32'(busy_o), 0);
    chk(refclk_sel_o == '0 && pll_sel_o == '0, "R11 selections", 32'(refclk_sel_o | pll_sel_o), 0);
    host_read(7'h40, r); chk(r == 0, "R11 chan reg", r, 0);
    host_read(7'h43, r); chk(r == 0, "R11 ofs reg", r, 0);
    check_state("R11");

    // R1: register widths and unmapped address
    host_write(7'h40, 32'hFFFF_FFFF);
    host_read(7'h40, r); chk(r == 32'h3FF, "R1 chan width", r, 32'h3FF);
    host_write(7'h43, 32'hFFFF_FFFF);
    host_read(7'h43, r); chk(r == 32'hF, "R1 ofs width", r, 32'hF);
    host_write(7'h44, 32'hFFFF_FFFF);
    host_read(7'h44, r); chk(r == 32'hFFFF, "R1 data width", r, 32'hFFFF);
    host_read(7'h41, r); chk(r == 0, "R1 unmapped", r, 0);
    // R2: command bits read back as 0
    host_read(7'h42, r); chk(r == 0, "R2 ctrl readback", r, 0);

    // R7 / R11: identity mapping visible in mapping words
    run_op(5, 2, 0, 2, "R7 refmap ch5");
    run_op(7, 3, 0, 2, "R7 pllmap ch7");
    // R5: boundary legal index, then out of range
    run_op(3, 0, 4, 1, "R5 refsel max");
    run_op(3, 0, 5, 1, "R8 refsel over");
    // R10: empty command keeps error, accepted one clears it
    run_op(3, 0, 1, 0, "R10 empty cmd");
    run_op(3, 0, 32'hFFF2, 1, "R10 clear err");
    // R6
    run_op(7, 1, 3, 1, "R6 pllsel max");
    run_op(7, 1, 4, 1, "R8 pllsel over");
    // R8: other rejections
    run_op(2, 2, 0, 1, "R8 write ro");
    run_op(8, 0, 1, 1, "R8 chan range");
    run_op(1, 0, 1, 3, "R8 both bits");
    // R4 / R7 readbacks
    run_op(3, 0, 0, 2, "R4 read refsel");
    run_op(7, 1, 0, 2, "R4 read pllsel");
    run_op(3, 2, 0, 2, "R7 refmap ch3");
    run_op(7, 3, 0, 2, "R7 pllmap sel");
    run_op(4, 9, 0, 2, "R7 high offset");

    // R9: command while busy
    host_write(7'h40, 32'd2);
    host_write(7'h43, 32'd1);
    host_write(7'h44, 32'd2);
    m_data = 32'd2;
    host_write(7'h42, 32'd1);
    host_write(7'h42, 32'd2);
    chk(busy_o == 1'b1, "R9 busy kept", 32'(busy_o), 1);
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b1, "R9 busy full length", 32'(busy_o), 1);
    @(negedge clk);
    chk(busy_o == 1'b0, "R9 busy fall", 32'(busy_o), 0);
    chk(pll_switch_o == 8'h04, "R9 original completes", 32'(pll_switch_o), 32'h04);
    m_pll[2] = 2; m_err = 1;
    check_state("R9");

    // random mix
    void'($urandom(32'd20240611));
    for (int k = 0; k < 200; k++) begin
      int ch, ofs, dat, bits, sel;
      ch  = int'($urandom % 11);
      ofs = int'($urandom % 6);
      dat = int'($urandom & 32'hFFFF);
      sel = int'($urandom % 10);
      bits = (sel < 5) ? 1 : (sel < 9) ? 2 : ((sel == 9) ? 3 : 0);
      run_op(ch, ofs, dat, bits, "R12 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule